// File: doc/BRIEF.md
# Packed Lane Add/Subtract/Compare Unit

This block is a single-stage SIMD arithmetic unit for a 64-bit datapath. It splits both operands into equal lanes of 8, 16 or 32 bits and applies one operation to every lane in the same cycle. The four operations are add, subtract, equality compare and signed greater-than compare.

Add and subtract can either wrap around inside each lane or saturate. Saturation comes in a signed form and an unsigned form. A compare writes a mask into each lane: every bit set when the test holds, every bit clear when it does not. The result is captured in an output register on any cycle in which the caller asserts `in_valid`. It appears one clock later together with `out_valid`.

Top module: `simd_addcmp_unit`

## Requirements
- R1: `lane_sz` picks the lane partition: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, and both 2 and 3 give two 32-bit lanes. Lane k occupies result bits [k*W +: W].
- R2: `opcode` 0 computes a+b and `opcode` 1 computes a-b per lane. In wrap mode (`sat_mode` 0 or 3) the carry or borrow out of each lane is dropped and the low W bits are kept.
- R3: No carry or borrow crosses a lane boundary, whatever the operation, lane size or saturation mode.
- R4: With `sat_mode` 1 (signed saturation) on 8-bit or 16-bit lanes, a two's-complement sum or difference above the lane maximum yields 0x7F/0x7FFF. A result below the lane minimum yields 0x80/0x8000.
- R5: With `sat_mode` 2 (unsigned saturation) on 8-bit or 16-bit lanes, an add that overflows yields all ones in the lane, and a subtract that would go below zero yields zero.
- R6: On 32-bit lanes, add and subtract always wrap, whatever the value of `sat_mode`.
- R7: `opcode` 2 sets a lane to all ones when the two operand lanes are equal and to all zeros otherwise. `sat_mode` has no effect.
- R8: `opcode` 3 sets a lane to all ones when the a-lane is greater than the b-lane as a signed two's-complement number, and to all zeros otherwise.
- R9: `result` and `out_valid` change one clock after the inputs are sampled. `out_valid` equals the previous cycle's `in_valid`. `result` holds its value on cycles whose previous `in_valid` was low.
- R10: After reset, `out_valid` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand (subtrahend for subtract) |
| lane_sz | input | 2 | Lane size select: 0 byte, 1 word, 2/3 doubleword |
| opcode | input | 2 | 0 add, 1 subtract, 2 compare-equal, 3 signed greater-than |
| sat_mode | input | 2 | 0/3 wrap, 1 signed saturate, 2 unsigned saturate |
| out_valid | output | 1 | Result register was loaded on the previous clock |
| result | output | 64 | Registered packed result |

## Verification
The hardest behaviour to reach from the ports is a lane that saturates while its neighbour does not. At the same time, the carry or borrow at that lane boundary must be one that would corrupt the neighbour if it leaked across. Uniform random operands almost never land on the lane extremes. The stimulus therefore builds each operand byte from a small set of edge values (0x00, 0x7F, 0x80, 0xFF) mixed with random bytes. It also steps through every lane size, opcode and saturation code, including the two alias codes. Directed vectors add the exact clamp points and all-ones-plus-one patterns across every lane.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int unsigned SLICE_W = 8;

  typedef enum logic [1:0] {
    LS_BYTE = 2'd0,
    LS_WORD = 2'd1,
    LS_DW   = 2'd2,
    LS_DW2  = 2'd3
  } lane_sz_e;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_CEQ = 2'd2,
    OP_CGT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SM_WRAP  = 2'd0,
    SM_SSAT  = 2'd1,
    SM_USAT  = 2'd2,
    SM_WRAP2 = 2'd3
  } sat_e;
endpackage

// File: rtl/simd_slice_adder.sv
module simd_slice_adder #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0]                   a,
  input  logic [DATA_W-1:0]                   b,
  input  logic                                sub,
  input  simd_pkg::lane_sz_e                  lane_sz,
  output logic [DATA_W-1:0]                   sum,
  output logic [DATA_W/simd_pkg::SLICE_W-1:0] slice_cout
);
  import simd_pkg::*;
  localparam int unsigned NSLICE = DATA_W / SLICE_W;

  logic [NSLICE-1:0] lane_start;

  // slice i begins a new lane when i is a multiple of the lane size in slices
  always_comb begin
    for (int i = 0; i < NSLICE; i++) begin
      unique case (lane_sz)
        LS_BYTE: lane_start[i] = 1'b1;
        LS_WORD: lane_start[i] = ((i % 2) == 0);
        default: lane_start[i] = ((i % 4) == 0);
      endcase
    end
  end

  always_comb begin
    logic              c_prev;
    logic              cin;
    logic [SLICE_W:0]  part;
    c_prev = 1'b0;
    sum = '0;
    slice_cout = '0;
    for (int i = 0; i < NSLICE; i++) begin
      cin  = lane_start[i] ? sub : c_prev;
      part = {1'b0, a[i*SLICE_W +: SLICE_W]}
           + {1'b0, b[i*SLICE_W +: SLICE_W] ^ {SLICE_W{sub}}}
           + {{SLICE_W{1'b0}}, cin};
      sum[i*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
      slice_cout[i] = part[SLICE_W];
      c_prev = part[SLICE_W];
    end
  end
endmodule

// File: rtl/simd_sat_clamp.sv
module simd_sat_clamp #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0]                   a,
  input  logic [DATA_W-1:0]                   b,
  input  logic                                sub,
  input  simd_pkg::lane_sz_e                  lane_sz,
  input  simd_pkg::sat_e                      sat_mode,
  input  logic [DATA_W-1:0]                   sum,
  input  logic [DATA_W/simd_pkg::SLICE_W-1:0] slice_cout,
  output logic [DATA_W-1:0]                   res
);
  import simd_pkg::*;
  localparam int unsigned NSLICE = DATA_W / SLICE_W;

  logic sat_on;
  assign sat_on = (lane_sz == LS_BYTE || lane_sz == LS_WORD)
                  && (sat_mode == SM_SSAT || sat_mode == SM_USAT);

  always_comb begin
    int   top;
    logic a_s, be_s, r_s, sovf, uovf;
    res = sum;
    for (int i = 0; i < NSLICE; i++) begin
      top  = (lane_sz == LS_BYTE) ? i : (i | 1);
      a_s  = a[top*SLICE_W + SLICE_W-1];
      be_s = b[top*SLICE_W + SLICE_W-1] ^ sub;
      r_s  = sum[top*SLICE_W + SLICE_W-1];
      sovf = (a_s == be_s) && (r_s != a_s);
      uovf = sub ? ~slice_cout[top] : slice_cout[top];
      if (sat_on && sat_mode == SM_SSAT && sovf) begin
        if (i == top) res[i*SLICE_W +: SLICE_W] = {a_s, {(SLICE_W-1){~a_s}}};
        else          res[i*SLICE_W +: SLICE_W] = {SLICE_W{~a_s}};
      end else if (sat_on && sat_mode == SM_USAT && uovf) begin
        res[i*SLICE_W +: SLICE_W] = {SLICE_W{~sub}};
      end
    end
  end
endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  input  simd_pkg::lane_sz_e lane_sz,
  input  logic               gt_sel,
  output logic [DATA_W-1:0]  mask
);
  import simd_pkg::*;
  localparam int unsigned NSIZE = 3;

  logic [DATA_W-1:0] m [NSIZE];

  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    localparam int unsigned LW = SLICE_W << g;
    localparam int unsigned NL = DATA_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic eq, gt;
      assign eq = (a[l*LW +: LW] == b[l*LW +: LW]);
      assign gt = ($signed(a[l*LW +: LW]) > $signed(b[l*LW +: LW]));
      assign m[g][l*LW +: LW] = {LW{gt_sel ? gt : eq}};
    end
  end

  always_comb begin
    unique case (lane_sz)
      LS_BYTE: mask = m[0];
      LS_WORD: mask = m[1];
      default: mask = m[2];
    endcase
  end
endmodule

// File: rtl/simd_addcmp_unit.sv
module simd_addcmp_unit #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        lane_sz,
  input  logic [1:0]        opcode,
  input  logic [1:0]        sat_mode,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  import simd_pkg::*;
  localparam int unsigned NSLICE = DATA_W / SLICE_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  lane_sz_e ls;
  op_e      op;
  sat_e     sm;
  assign ls = lane_sz_e'(lane_sz);
  assign op = op_e'(opcode);
  assign sm = sat_e'(sat_mode);

  logic [DATA_W-1:0] add_sum, arith_res, cmp_mask;
  logic [NSLICE-1:0] add_cout;
  logic              is_sub;
  assign is_sub = (op == OP_SUB);

  simd_slice_adder #(.DATA_W(DATA_W)) u_add (
    .a(op_a), .b(op_b), .sub(is_sub), .lane_sz(ls),
    .sum(add_sum), .slice_cout(add_cout)
  );

  simd_sat_clamp #(.DATA_W(DATA_W)) u_clamp (
    .a(op_a), .b(op_b), .sub(is_sub), .lane_sz(ls), .sat_mode(sm),
    .sum(add_sum), .slice_cout(add_cout), .res(arith_res)
  );

  simd_lane_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a(op_a), .b(op_b), .lane_sz(ls), .gt_sel(op == OP_CGT), .mask(cmp_mask)
  );

  logic [DATA_W-1:0] res_q, res_d;
  logic              vld_q, vld_d;

  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    if (in_valid) begin
      res_d = (op == OP_CEQ || op == OP_CGT) ? cmp_mask : arith_res;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign result    = res_q;
  assign out_valid = vld_q;
endmodule

// File: rtl/simd_addcmp_chk.sv
module simd_addcmp_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [1:0]        lane_sz,
  input logic [1:0]        opcode,
  input logic [1:0]        sat_mode,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  localparam int unsigned NB = DATA_W / 8;

  function automatic logic bytes_are_masks(logic [DATA_W-1:0] r);
    logic ok = 1'b1;
    for (int i = 0; i < NB; i++)
      if (r[i*8 +: 8] != 8'h00 && r[i*8 +: 8] != 8'hFF) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic bytes_not_below(logic [DATA_W-1:0] r, logic [DATA_W-1:0] a);
    logic ok = 1'b1;
    for (int i = 0; i < NB; i++)
      if (r[i*8 +: 8] < a[i*8 +: 8]) ok = 1'b0;
    return ok;
  endfunction

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid); // R9
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> $stable(result)); // R9
  AST_CMP_MASK: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && opcode[1]) |=> bytes_are_masks(result)); // R7
  AST_EQ_SELF: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && opcode == 2'd2 && op_a == op_b) |=> (result == {DATA_W{1'b1}})); // R7
  AST_GT_SELF: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && opcode == 2'd3 && op_a == op_b) |=> (result == '0)); // R8
  AST_DW_WRAP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && lane_sz[1] && opcode == 2'd0)
      |=> (result[31:0] == $past(op_a[31:0] + op_b[31:0]))); // R6
  AST_USAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && opcode == 2'd0 && sat_mode == 2'd2 && lane_sz == 2'd0)
      |=> bytes_not_below(result, $past(op_a))); // R5
endmodule

bind simd_addcmp_unit simd_addcmp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .lane_sz(lane_sz), .opcode(opcode), .sat_mode(sat_mode),
  .out_valid(out_valid), .result(result)
);

// File: tb/sim_simd_addcmp_unit.sv
`timescale 1ns/1ps
module sim_simd_addcmp_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] op_a, op_b;
  logic [1:0]  lane_sz, opcode, sat_mode;
  logic        out_valid;
  logic [63:0] result;

  int total = 0;
  int bad   = 0;
  logic [63:0] last_exp = '0;

  always #2.5 clk = ~clk;

  simd_addcmp_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .lane_sz(lane_sz), .opcode(opcode), .sat_mode(sat_mode),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                        logic [1:0] sz, logic [1:0] op, logic [1:0] sat);
    int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    logic [63:0] r = '0;
    for (int l = 0; l < 64 / w; l++) begin
      longint mx = (longint'(1) << w) - 1;
      longint hi = (longint'(1) << (w - 1)) - 1;
      longint lo = -(longint'(1) << (w - 1));
      longint ua = longint'((a >> (l * w)) & 64'(mx));
      longint ub = longint'((b >> (l * w)) & 64'(mx));
      longint sa = (ua > hi) ? ua - mx - 1 : ua;
      longint sb = (ub > hi) ? ub - mx - 1 : ub;
      longint v;
      bit satok = (w < 32);
      case (op)
        2'd0: begin
          if (satok && sat == 2'd1) begin v = sa + sb; v = (v > hi) ? hi : (v < lo) ? lo : v; end
          else if (satok && sat == 2'd2) v = (ua + ub > mx) ? mx : ua + ub;
          else v = ua + ub;
        end
        2'd1: begin
          if (satok && sat == 2'd1) begin v = sa - sb; v = (v > hi) ? hi : (v < lo) ? lo : v; end
          else if (satok && sat == 2'd2) v = (ua < ub) ? 0 : ua - ub;
          else v = ua - ub;
        end
        2'd2:    v = (ua == ub) ? mx : 0;
        default: v = (sa > sb) ? mx : 0;
      endcase
      r = r | ((64'(v) & 64'(mx)) << (l * w));
    end
    return r;
  endfunction

  function automatic string tag_of(logic [1:0] sz, logic [1:0] op, logic [1:0] sat);
    if (op == 2'd2) return "R7";
    if (op == 2'd3) return "R8";
    if (sz[1]) return "R6";
    if (sat == 2'd1) return "R4";
    if (sat == 2'd2) return "R5";
    return "R2";
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(logic [63:0] a, logic [63:0] b, logic [1:0] sz,
                     logic [1:0] op, logic [1:0] sat, string tag);
    op_a = a; op_b = b; lane_sz = sz; opcode = op; sat_mode = sat; in_valid = 1'b1;
    last_exp = model(a, b, sz, op, sat);
    @(negedge clk);
    check(tag, result, last_exp);
    check("R9", {63'd0, out_valid}, 64'd1);
  endtask

  task automatic idle(logic [63:0] a, logic [63:0] b);
    op_a = a; op_b = b; in_valid = 1'b0; opcode = 2'd0; sat_mode = 2'd0; lane_sz = 2'd0;
    @(negedge clk);
    check("R9", result, last_exp);
    check("R9", {63'd0, out_valid}, 64'd0);
  endtask

  function automatic logic [63:0] edge_word();
    logic [63:0] r;
    for (int i = 0; i < 8; i++) begin
      case ($urandom % 5)
        0: r[i*8 +: 8] = 8'h00;
        1: r[i*8 +: 8] = 8'h7F;
        2: r[i*8 +: 8] = 8'h80;
        3: r[i*8 +: 8] = 8'hFF;
        default: r[i*8 +: 8] = 8'($urandom);
      endcase
    end
    return r;
  endfunction

  initial begin
    #200us;
    bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
    lane_sz = '0; opcode = '0; sat_mode = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", result, 64'd0);
    check("R10", {63'd0, out_valid}, 64'd0);

    // wrap and saturation at byte clamp points
    run(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 2'd0, 2'd0, 2'd0, "R2");
    run(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 2'd0, 2'd0, 2'd1, "R4");
    run(64'h8080_8080_8080_8080, 64'h0101_0101_0101_0101, 2'd0, 2'd1, 2'd1, "R4");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'd0, 2'd0, 2'd2, "R5");
    run(64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001, 2'd1, 2'd1, 2'd2, "R5");
    run(64'h8000_7FFF_8000_7FFF, 64'h0001_FFFF_0001_FFFF, 2'd1, 2'd1, 2'd1, "R4");
    // carries and borrows must stay inside each lane
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'd0, 2'd0, 2'd0, "R3");
    run(64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001, 2'd1, 2'd1, 2'd0, "R3");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'd2, 2'd0, 2'd1, "R3");
    // doubleword ignores saturation select
    run(64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'd2, 2'd0, 2'd1, "R6");
    run(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 2'd3, 2'd1, 2'd2, "R6");
    // alias codes
    run(64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 2'd3, 2'd0, 2'd0, "R1");
    run(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 2'd0, 2'd0, 2'd3, "R2");
    // compares
    run(64'h1122_3344_5566_7788, 64'h1122_0044_5566_0088, 2'd0, 2'd2, 2'd1, "R7");
    run(64'h1122_3344_5566_7788, 64'h1122_3345_5566_7788, 2'd1, 2'd2, 2'd0, "R7");
    run(64'h8000_0000_7F01_0180, 64'h7F00_0000_8001_0170, 2'd0, 2'd3, 2'd0, "R8");
    run(64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF, 2'd2, 2'd3, 2'd0, "R8");
    run(64'h0001_FFFF_8000_7FFF, 64'hFFFF_0001_7FFF_8000, 2'd1, 2'd3, 2'd2, "R8");
    // hold while idle
    idle(64'hDEAD_BEEF_0000_FFFF, 64'h0123_4567_89AB_CDEF);
    idle(64'h0, 64'h0);

    for (int n = 0; n < 600; n++) begin
      logic [1:0] sz  = 2'($urandom);
      logic [1:0] op  = 2'($urandom);
      logic [1:0] sat = 2'($urandom);
      logic [63:0] a = edge_word();
      logic [63:0] b = ($urandom % 8 == 0) ? a : edge_word();
      if ($urandom % 6 == 0) idle(edge_word(), edge_word());
      else run(a, b, sz, op, sat, tag_of(sz, op, sat));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule